// File: doc/BRIEF.md
# Byte-Loaded SRAM Address Expander

This block lets a microcontroller with only a few spare pins drive a wide SRAM address bus and also select several expansion devices. The host presents an 8-bit data byte, a 3-bit state-select code and an active-low chip-select. Three of the eight codes each load one byte-wide address latch. Together these latches form a 19-bit address, which is enough for a 512KB part. A 128KB part uses only the low 17 bits and a 32KB part uses only the low 15 bits.

The other five codes are not address-map entries. Each one drives its own active-low expansion strobe, which can serve as a chip-select or a latch-enable for a peripheral. Because each address byte sits in its own register, the SRAM address stays fixed while the host works through the strobe codes.

Top module: `sram_addr_expander`

## Requirements
- R1: While synchronous reset is high, every strobe output is high. At the first clock edge with reset high, the address output becomes zero.
- R2: At a rising clock edge with chip-select low and code 0, address bits 7:0 take the data byte. All other address bits keep their value.
- R3: At a rising clock edge with chip-select low and code 1, address bits 15:8 take the data byte. All other address bits keep their value.
- R4: At a rising clock edge with chip-select low and code 2, address bits 18:16 take data bits 2:0. Data bits 7:3 have no effect, and address bits 15:0 keep their value.
- R5: At a clock edge with chip-select high, the address does not change, whatever the code and data are.
- R6: While chip-select is low and reset is low, code 3+k (k from 0 to 4) drives strobe bit k low. This follows the inputs without waiting for a clock edge.
- R7: At most one strobe is low at any time. All strobes are high when chip-select is high or the code is 0, 1 or 2.
- R8: Clock edges that see codes 3 to 7 leave the address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the address latches |
| rst | input | 1 | Synchronous reset, active high |
| host_cs_n | input | 1 | Chip-select from the host, active low |
| host_sel | input | 3 | State-select code |
| host_data | input | 8 | Data byte from the host |
| sram_addr | output | 19 | Registered SRAM address |
| xp_strobe_n | output | 5 | Expansion strobes, active low; bit k belongs to code 3+k |

## Verification
The hardest case to reach is a byte write that lands on top of a previously loaded address while the other bytes hold values that differ from zero. Only then does a load that wrongly disturbs a neighbouring latch show up at the ports. The stimulus first loads distinct patterns into all three latches. It then mixes random codes, data and chip-select states, so that loads, writes blocked by a high chip-select, and strobe cycles interleave over a fully populated address. Code 2 is driven with data whose upper bits are set, to show that those bits are ignored.

// File: rtl/sram_xp_pkg.sv
package sram_xp_pkg;

    localparam int DATA_W    = 8;
    localparam int SEL_W     = 3;
    localparam int ADDR_W    = 19;
    localparam int NUM_CODES = 1 << SEL_W;
    localparam int NUM_LATCH = (ADDR_W + DATA_W - 1) / DATA_W;
    localparam int NUM_STRB  = NUM_CODES - NUM_LATCH;
    localparam int STRB_BASE = NUM_LATCH;

    typedef logic [DATA_W-1:0]   byte_t;
    typedef logic [SEL_W-1:0]    sel_t;
    typedef logic [ADDR_W-1:0]   addr_t;
    typedef logic [NUM_LATCH-1:0] load_vec_t;
    typedef logic [NUM_STRB-1:0] strb_vec_t;

    typedef struct packed {
        logic  active;
        sel_t  code;
        byte_t data;
    } host_req_t;

    // Width of the latch that owns address slice idx.
    function automatic int latch_width(input int idx);
        int rem;
        rem = ADDR_W - idx * DATA_W;
        return (rem < DATA_W) ? rem : DATA_W;
    endfunction

    function automatic int latch_lsb(input int idx);
        return idx * DATA_W;
    endfunction

endpackage

// File: rtl/sel_decode.sv
module sel_decode
    import sram_xp_pkg::*;
(
    input  host_req_t req,
    output load_vec_t load_en,
    output strb_vec_t strobe_req
);

    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_load
        assign load_en[i] = req.active && (req.code == sel_t'(i));
    end

    for (genvar j = 0; j < NUM_STRB; j++) begin : g_strb
        assign strobe_req[j] = req.active && (req.code == sel_t'(j + STRB_BASE));
    end

endmodule

// File: rtl/byte_latch.sv
module byte_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= d;
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q)) else $error("latch changed without enable"); // R5

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
        en |=> (q == $past(d))) else $error("latch missed load"); // R2

endmodule

// File: rtl/strobe_drive.sv
module strobe_drive
    import sram_xp_pkg::*;
(
    input  logic      rst,
    input  strb_vec_t strobe_req,
    output strb_vec_t strobe_n
);

    always_comb begin
        if (rst)
            strobe_n = '1;
        else
            strobe_n = ~strobe_req;
    end

endmodule

// File: rtl/sram_addr_expander.sv
module sram_addr_expander
    import sram_xp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs_n,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [DATA_W-1:0] host_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [NUM_STRB-1:0] xp_strobe_n
);

    host_req_t req;
    load_vec_t load_en;
    strb_vec_t strobe_req;

    assign req.active = ~host_cs_n;
    assign req.code   = host_sel;
    assign req.data   = host_data;

    sel_decode u_dec (
        .req        (req),
        .load_en    (load_en),
        .strobe_req (strobe_req)
    );

    for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
        localparam int LW  = latch_width(g);
        localparam int LSB = latch_lsb(g);
        byte_latch #(.W(LW)) u_lat (
            .clk (clk),
            .rst (rst),
            .en  (load_en[g]),
            .d   (req.data[LW-1:0]),
            .q   (sram_addr[LSB +: LW])
        );
    end

    strobe_drive u_drv (
        .rst        (rst),
        .strobe_req (strobe_req),
        .strobe_n   (xp_strobe_n)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (sram_addr == '0)) else $error("reset did not clear"); // R1

    AST_LOAD_LOW: assert property (@(posedge clk) disable iff (rst)
        (!host_cs_n && host_sel == 3'd0) |=>
        (sram_addr[7:0] == $past(host_data)) && (sram_addr[18:8] == $past(sram_addr[18:8])))
        else $error("low byte load wrong"); // R2

    AST_LOAD_MID: assert property (@(posedge clk) disable iff (rst)
        (!host_cs_n && host_sel == 3'd1) |=>
        (sram_addr[15:8] == $past(host_data)) && (sram_addr[7:0] == $past(sram_addr[7:0])))
        else $error("middle byte load wrong"); // R3

    AST_LOAD_TOP: assert property (@(posedge clk) disable iff (rst)
        (!host_cs_n && host_sel == 3'd2) |=>
        (sram_addr[18:16] == $past(host_data[2:0])) && (sram_addr[15:0] == $past(sram_addr[15:0])))
        else $error("top bits load wrong"); // R4

    AST_HOLD_DESELECT: assert property (@(posedge clk) disable iff (rst)
        host_cs_n |=> $stable(sram_addr)) else $error("address moved while deselected"); // R5

    AST_STROBE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!host_cs_n && host_sel == 3'd3) |-> !xp_strobe_n[0]) else $error("strobe 0 missing"); // R6

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~xp_strobe_n)) else $error("several strobes low"); // R7

    AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (host_cs_n || host_sel < 3'd3) |-> (&xp_strobe_n)) else $error("strobe low while idle"); // R7

    AST_HOLD_EXPANSION: assert property (@(posedge clk) disable iff (rst)
        (!host_cs_n && host_sel >= 3'd3) |=> $stable(sram_addr)) else $error("strobe cycle moved address"); // R8

endmodule

// File: tb/sram_addr_expander_tb.sv
module sram_addr_expander_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_cs_n = 1'b0;
    logic [2:0]  host_sel = 3'd4;
    logic [7:0]  host_data = 8'hFF;
    logic [18:0] sram_addr;
    logic [4:0]  xp_strobe_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [18:0] exp_addr = '0;

    always #2.5 clk = ~clk;

    sram_addr_expander u_dut (
        .clk         (clk),
        .rst         (rst),
        .host_cs_n   (host_cs_n),
        .host_sel    (host_sel),
        .host_data   (host_data),
        .sram_addr   (sram_addr),
        .xp_strobe_n (xp_strobe_n)
    );

    function automatic logic [4:0] exp_strobe(input logic r, input logic csn, input logic [2:0] s);
        if (r || csn || s < 3'd3) return 5'h1F;
        return ~(5'b00001 << (s - 3'd3));
    endfunction

    function automatic logic [18:0] next_addr(input logic [18:0] a, input logic csn,
                                              input logic [2:0] s, input logic [7:0] d);
        logic [18:0] n;
        n = a;
        if (!csn) begin
            case (s)
                3'd0: n[7:0]   = d;
                3'd1: n[15:8]  = d;
                3'd2: n[18:16] = d[2:0];
                default: ;
            endcase
        end
        return n;
    endfunction

    function automatic string addr_tag(input logic csn, input logic [2:0] s);
        if (csn) return "R5";
        case (s)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic csn, input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        host_cs_n = csn;
        host_sel  = s;
        host_data = d;
        #1;
        check((!csn && s >= 3'd3) ? "R6" : "R7", 32'(xp_strobe_n), 32'(exp_strobe(1'b0, csn, s)));
        @(posedge clk);
        #1;
        exp_addr = next_addr(exp_addr, csn, s, d);
        check(addr_tag(csn, s), 32'(sram_addr), 32'(exp_addr));
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: strobes held high during reset although a strobe code is present
        check("R1", 32'(xp_strobe_n), 32'h1F);
        check("R1", 32'(sram_addr), 32'h0);
        rst = 1'b0;
        host_cs_n = 1'b1;

        // directed loads of distinct patterns
        step(1'b0, 3'd0, 8'h3C);
        step(1'b0, 3'd1, 8'hA5);
        step(1'b0, 3'd2, 8'hFD);   // R4: upper data bits ignored, top = 3'b101
        check("R4", 32'(sram_addr), 32'h5A53C);
        step(1'b1, 3'd0, 8'h00);   // R5: deselected write has no effect
        step(1'b1, 3'd2, 8'h07);
        for (int k = 3; k < 8; k++) step(1'b0, 3'(k), 8'h55);  // R6, R8
        step(1'b0, 3'd2, 8'h02);
        step(1'b0, 3'd0, 8'hFF);

        for (int i = 0; i < 400; i++) begin
            logic csn;
            csn = (($urandom % 4) == 0);
            step(csn, 3'($urandom % 8), 8'($urandom));
        end

        // R1: reset in the middle of activity clears the address
        @(negedge clk);
        rst = 1'b1;
        host_cs_n = 1'b0;
        host_sel = 3'd6;
        #1;
        check("R1", 32'(xp_strobe_n), 32'h1F);
        @(posedge clk);
        #1;
        check("R1", 32'(sram_addr), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        exp_addr = '0;
        step(1'b0, 3'd1, 8'h81);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule